// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block is the host-side engine of an 8-bit multiplexed NAND bus. A requester hands it one operation at a time. The operation is made of:
- a leading command byte;
- zero to five address cycles, cut from a 31-bit linear address;
- an optional trailing command;
- a count of data bytes to read back.

The sequencer drives the chip-enable, command-latch, address-latch, write-strobe and read-strobe lines. It places each byte on the shared data lines for the duration of its write strobe. It releases those lines whenever it reads.

Strobe timing comes from clock-count inputs, so one design serves any clock rate. After a trailing command, the block waits until the ready/busy line reports busy, or until a programmable timeout runs out. It then waits for ready before it reads any data.

The linear address is split as follows. Bits 0–11 are the column within the page, bits 12–17 the page within the block, bit 18 the plane, and bits 19–30 the block. The column needs two cycles and the row needs three, and unused upper bits are padded with zeros. A row-only flag skips the two column cycles, which an erase needs.

After a device-identification command (90h), a status request (70h) needs a dummy 00h command first. The sequencer inserts that dummy command on its own.

Top module: `nand_cmd_seq`

## Requirements
- R1: A byte is latched as a command when the write strobe (active low) rises with the command-latch line high. It is latched as an address when the write strobe rises with the address-latch line high. The two latch lines are never high together. The data lines are driven and held steady for the whole write-strobe low phase and the rising edge.
- R2: Chip enable (active low) goes low from the first bus cycle of an accepted request until its completion. It is high while the block is idle.
- R3: The address cycles carry the following bytes, numbered 1 to 5:
  - cycle 1: address bits 7:0;
  - cycle 2: bits 11:8 on data lines 3:0, with lines 7:4 low;
  - cycle 3: bits 19:12;
  - cycle 4: bits 27:20;
  - cycle 5: bits 30:28 on lines 2:0, with lines 7:3 low.

  A request asks for N cycles. These are cycles 1..N, or cycles 3..N+2 when the row-only flag is set.
- R4: The write strobe is low for `cfg_we_lo` clocks, and stays high for `cfg_we_hi` clocks before the next write strobe. The read strobe is low for `cfg_re_lo` clocks, and stays high for `cfg_we_hi` clocks between read pulses. A count of 0 acts as 1.
- R5: After a trailing command, the block waits until ready/busy is low or until `cfg_busy_to` clocks have passed. It then waits for ready/busy high. No read strobe falls, and the request does not complete, before ready/busy has returned high.
- R6: A request reads `req_nread` bytes, one per read-strobe pulse. Each byte is sampled in the last clock of the strobe's low phase and presented with a one-clock `rd_valid` pulse. The first read strobe is preceded by `cfg_rd_dly` clocks (0 acts as 1). The host never drives the data lines while the read strobe is low or while idle.
- R7: If the previous accepted request's leading command was 90h, a request whose leading command is 70h is issued as a 00h command followed by 70h. Otherwise 70h is issued alone.
- R8: A request is rejected if its last address cycle would lie beyond cycle 5, that is N > 5, or N > 3 with row-only set. A rejected request raises `err` for one clock, produces no bus activity and no `done`.
- R9: Each accepted request produces exactly one one-clock `done` pulse at its end. `busy` is high from acceptance until then, and `req_ready` is high only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Block idle and able to take a request |
| req_cmd | input | 8 | Leading command byte |
| req_addr | input | 31 | Linear address |
| req_naddr | input | 3 | Number of address cycles |
| req_row_only | input | 1 | Start the address at the first row cycle |
| req_has_post | input | 1 | Issue a trailing command and wait for ready |
| req_post_cmd | input | 8 | Trailing command byte |
| req_nread | input | RDW | Number of bytes to read |
| cfg_we_lo | input | TW | Write-strobe low clocks |
| cfg_we_hi | input | TW | Strobe high clocks between pulses |
| cfg_re_lo | input | TW | Read-strobe low clocks |
| cfg_rd_dly | input | TW | Clocks before the first read strobe |
| cfg_busy_to | input | TOW | Clocks to wait for busy to appear |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | One-clock rejection pulse |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data lines, host to device |
| nand_dq_oe | output | 1 | Host drives data lines |
| nand_dq_i | input | 8 | Data lines, device to host |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
Directed requests cover the following cases:
- an identification read followed by two status reads, which shows the dummy command is inserted once and only once;
- a full five-cycle page read with a busy wait;
- a row-only erase;
- a trailing command where ready/busy never drops, which separates the busy-seen path from the timeout path;
- three out-of-range address requests.

Random requests then mix every address-cycle count, both start offsets, random trailing commands, read lengths of zero to five, and strobe counts of zero to three. Bench functions compute the expected latch sequence, address bytes and read data for each one. A zero strobe count separates the "acts as 1" rule from a literal count, and the per-pulse width measurements catch an off-by-one in either phase.

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
  parameter int TW = 6,
  parameter int TOW = 12,
  parameter int RDW = 8,
  parameter logic [7:0] ID_CMD = 8'h90,
  parameter logic [7:0] STATUS_CMD = 8'h70,
  parameter logic [7:0] DUMMY_CMD = 8'h00
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [7:0]     req_cmd,
  input  logic [30:0]    req_addr,
  input  logic [2:0]     req_naddr,
  input  logic           req_row_only,
  input  logic           req_has_post,
  input  logic [7:0]     req_post_cmd,
  input  logic [RDW-1:0] req_nread,
  input  logic [TW-1:0]  cfg_we_lo,
  input  logic [TW-1:0]  cfg_we_hi,
  input  logic [TW-1:0]  cfg_re_lo,
  input  logic [TW-1:0]  cfg_rd_dly,
  input  logic [TOW-1:0] cfg_busy_to,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic           rd_valid,
  output logic [7:0]     rd_data,
  output logic           nand_ce_n,
  output logic           nand_cle,
  output logic           nand_ale,
  output logic           nand_we_n,
  output logic           nand_re_n,
  output logic [7:0]     nand_dq_o,
  output logic           nand_dq_oe,
  input  logic [7:0]     nand_dq_i,
  input  logic           nand_rb_n
);
  localparam int CW = (TOW > TW) ? TOW : TW;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_CMD, S_ADDR, S_POST, S_WLO, S_WHI, S_RDLY, S_READ
  } st_t;

  st_t st, tgt, after_addr;
  logic adv, ph, has_post_q, id_flag;
  logic [CW-1:0] cnt;
  logic [2:0] aidx, aend;
  logic [7:0] cmd_q, post_q, abyte;
  logic [30:0] addr_q;
  logic [RDW-1:0] nrd_q;

  function automatic logic [CW-1:0] ld(input logic [TW-1:0] v);
    return (v == '0) ? '0 : CW'(v) - CW'(1);
  endfunction

  wire [3:0] req_last = {1'b0, req_naddr} + (req_row_only ? 4'd2 : 4'd0);
  wire req_bad = req_last > 4'd5;
  wire wr_st = st inside {S_PRE, S_CMD, S_ADDR, S_POST};
  wire slot_end = wr_st && ph && (cnt == '0);

  assign busy = (st != S_IDLE);
  assign req_ready = (st == S_IDLE);
  assign nand_ce_n = (st == S_IDLE);
  assign nand_cle = st inside {S_PRE, S_CMD, S_POST};
  assign nand_ale = (st == S_ADDR);
  assign nand_we_n = !(wr_st && !ph);
  assign nand_re_n = !(st == S_READ && !ph);
  assign nand_dq_oe = wr_st;

  always_comb begin
    case (aidx)
      3'd0: abyte = addr_q[7:0];
      3'd1: abyte = {4'h0, addr_q[11:8]};
      3'd2: abyte = addr_q[19:12];
      3'd3: abyte = addr_q[27:20];
      default: abyte = {5'h0, addr_q[30:28]};
    endcase
    case (st)
      S_PRE:  nand_dq_o = DUMMY_CMD;
      S_CMD:  nand_dq_o = cmd_q;
      S_ADDR: nand_dq_o = abyte;
      S_POST: nand_dq_o = post_q;
      default: nand_dq_o = 8'h00;
    endcase
  end

  always_comb begin
    after_addr = has_post_q ? S_POST : ((nrd_q != '0) ? S_RDLY : S_IDLE);
    adv = 1'b0;
    tgt = S_IDLE;
    case (st)
      S_IDLE: begin
        adv = req_valid && !req_bad;
        tgt = (req_cmd == STATUS_CMD && id_flag) ? S_PRE : S_CMD;
      end
      S_PRE:  begin adv = slot_end; tgt = S_CMD; end
      S_CMD:  begin adv = slot_end; tgt = (aidx != aend) ? S_ADDR : after_addr; end
      S_ADDR: begin adv = slot_end && (3'(aidx + 3'd1) == aend); tgt = after_addr; end
      S_POST: begin adv = slot_end; tgt = S_WLO; end
      S_WLO:  begin adv = !nand_rb_n || cnt == '0; tgt = S_WHI; end
      S_WHI:  begin adv = nand_rb_n; tgt = (nrd_q != '0) ? S_RDLY : S_IDLE; end
      S_RDLY: begin adv = (cnt == '0); tgt = S_READ; end
      S_READ: begin adv = ph && cnt == '0 && nrd_q == RDW'(1); tgt = S_IDLE; end
      default: begin adv = 1'b1; tgt = S_IDLE; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 1'b0; cnt <= '0; aidx <= '0; aend <= '0;
      cmd_q <= '0; post_q <= '0; has_post_q <= 1'b0; addr_q <= '0; nrd_q <= '0;
      id_flag <= 1'b0; done <= 1'b0; err <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      done <= 1'b0;
      err <= 1'b0;
      rd_valid <= 1'b0;
      if (st == S_IDLE && req_valid) begin
        if (req_bad) err <= 1'b1;
        else begin
          cmd_q <= req_cmd; post_q <= req_post_cmd; has_post_q <= req_has_post;
          addr_q <= req_addr; nrd_q <= req_nread;
          aidx <= req_row_only ? 3'd2 : 3'd0;
          aend <= req_last[2:0];
        end
      end
      if (st == S_CMD && slot_end) id_flag <= (cmd_q == ID_CMD);
      if (adv) begin
        st <= tgt;
        case (tgt)
          S_PRE, S_CMD, S_ADDR, S_POST: begin ph <= 1'b0; cnt <= ld(cfg_we_lo); end
          S_WLO:  cnt <= CW'(cfg_busy_to);
          S_RDLY: cnt <= ld(cfg_rd_dly);
          S_READ: begin ph <= 1'b0; cnt <= ld(cfg_re_lo); end
          S_IDLE: done <= 1'b1;
          default: ;
        endcase
      end else if (wr_st) begin
        if (cnt != '0) cnt <= cnt - CW'(1);
        else if (!ph) begin ph <= 1'b1; cnt <= ld(cfg_we_hi); end
        else begin aidx <= aidx + 3'd1; ph <= 1'b0; cnt <= ld(cfg_we_lo); end
      end else if (st == S_WLO || st == S_RDLY) begin
        cnt <= cnt - CW'(1);
      end else if (st == S_READ) begin
        if (cnt != '0) cnt <= cnt - CW'(1);
        else if (!ph) begin
          rd_valid <= 1'b1; rd_data <= nand_dq_i; ph <= 1'b1; cnt <= ld(cfg_we_hi);
        end else begin
          nrd_q <= nrd_q - RDW'(1); ph <= 1'b0; cnt <= ld(cfg_re_lo);
        end
      end
    end
  end

  assert_cle_ale_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  assert_we_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |=> (nand_dq_oe && $stable(nand_dq_o) && $stable(nand_cle) && $stable(nand_ale)));
  assert_ce_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
  assert_no_drive_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);
  assert_reject_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (nand_ce_n && !done));
  assert_done_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && nand_ce_n));
endmodule

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_row_only = 0, req_has_post = 0;
  logic [7:0] req_cmd = 0, req_post_cmd = 0;
  logic [30:0] req_addr = 0;
  logic [2:0] req_naddr = 0;
  logic [7:0] req_nread = 0;
  logic [5:0] cfg_we_lo = 1, cfg_we_hi = 1, cfg_re_lo = 1, cfg_rd_dly = 1;
  logic [11:0] cfg_busy_to = 40;
  logic req_ready, busy, done, err, rd_valid;
  logic [7:0] rd_data, nand_dq_o, dq_in;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic rb_n = 1'b1;

  int cyc = 0, nchk = 0, nfail = 0;
  int rd_idx = 0, pat_seed = 0;
  assign dq_in = 8'((rd_idx * 29 + pat_seed) % 256);

  nand_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_naddr(req_naddr),
    .req_row_only(req_row_only), .req_has_post(req_has_post),
    .req_post_cmd(req_post_cmd), .req_nread(req_nread),
    .cfg_we_lo(cfg_we_lo), .cfg_we_hi(cfg_we_hi), .cfg_re_lo(cfg_re_lo),
    .cfg_rd_dly(cfg_rd_dly), .cfg_busy_to(cfg_busy_to),
    .busy(busy), .done(done), .err(err), .rd_valid(rd_valid), .rd_data(rd_data),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(dq_in), .nand_rb_n(rb_n));

  // bus monitor and device model state
  int ev_n, rd_n, ncl, arm_ncl, viol_w, viol_busy, viol_oe, ce_cnt, done_cnt;
  int done_t, rb_rise_t, post_rise_t, we_fall_t, re_fall_t, last_we_rise_t, re_rise_t;
  bit we_ok, re_ok, id_state;
  int exp_lo, exp_hi, exp_rlo, bz_wait = -1, bz_cnt, plan_wait, plan_len;
  logic [7:0] ev_byte [0:63];
  logic [1:0] ev_kind [0:63];
  logic [7:0] rd_got [0:63];
  logic pwe = 1, pre = 1, pcle = 0, pale = 0;
  logic [7:0] pdq = 0;
  int exp_n;
  logic [7:0] exp_byte [0:15];
  logic [1:0] exp_kind [0:15];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!nand_ce_n) ce_cnt++;
    if (done) begin done_cnt++; done_t = cyc; end
    if (nand_dq_oe && !nand_re_n) viol_oe++;
    if (rd_valid && rd_n < 64) begin rd_got[rd_n] = rd_data; rd_n++; end
    if (pwe && !nand_we_n) begin
      if (we_ok && cyc - last_we_rise_t != exp_hi) viol_w++;
      we_fall_t = cyc;
    end
    if (!pwe && nand_we_n) begin
      if (cyc - we_fall_t != exp_lo) viol_w++;
      last_we_rise_t = cyc; we_ok = 1;
      if (ev_n < 64) begin
        ev_byte[ev_n] = pdq; ev_kind[ev_n] = {pale, pcle}; ev_n++;
      end
      if (pcle) begin
        ncl++;
        if (ncl == arm_ncl) begin post_rise_t = cyc; bz_wait = plan_wait; end
      end
    end
    if (pre && !nand_re_n) begin
      if (re_ok && cyc - re_rise_t != exp_hi) viol_w++;
      if (!rb_n) viol_busy++;
      re_fall_t = cyc;
    end
    if (!pre && nand_re_n) begin
      if (cyc - re_fall_t != exp_rlo) viol_w++;
      re_rise_t = cyc; re_ok = 1; rd_idx++;
    end
    if (bz_wait > 0) bz_wait--;
    else if (bz_wait == 0) begin rb_n = 0; bz_cnt = plan_len; bz_wait = -1; end
    else if (!rb_n) begin
      if (bz_cnt > 0) bz_cnt--;
      else begin rb_n = 1; rb_rise_t = cyc; end
    end
    pwe = nand_we_n; pre = nand_re_n; pcle = nand_cle; pale = nand_ale; pdq = nand_dq_o;
    if (cyc >= 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  function automatic logic [7:0] addr_byte(input logic [30:0] a, input int i);
    logic [11:0] col = a[11:0];
    logic [5:0] pg = a[17:12];
    logic pl = a[18];
    logic [11:0] blk = a[30:19];
    case (i)
      0: return col[7:0];
      1: return {4'h0, col[11:8]};
      2: return {blk[0], pl, pg};
      3: return blk[8:1];
      default: return {5'h0, blk[11:9]};
    endcase
  endfunction

  function automatic int atl1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic add_exp(input logic [1:0] k, input logic [7:0] b);
    exp_kind[exp_n] = k; exp_byte[exp_n] = b; exp_n++;
  endtask

  task automatic run_req(input logic [7:0] c, input logic [30:0] a, input int na,
                         input bit ro, input bit hp, input logic [7:0] pc,
                         input int nr, input int pwait, input int plen);
    bit bad = (na + (ro ? 2 : 0)) > 5;
    int s = ro ? 2 : 0;
    int ncmd = 0, g = 0;
    bit dummy = (c == 8'h70) && id_state;
    exp_n = 0;
    if (!bad) begin
      if (dummy) begin add_exp(2'b01, 8'h00); ncmd++; end
      add_exp(2'b01, c); ncmd++;
      for (int i = s; i < s + na; i++) add_exp(2'b10, addr_byte(a, i));
      if (hp) begin add_exp(2'b01, pc); ncmd++; end
    end
    arm_ncl = hp ? ncmd : -1;
    ev_n = 0; rd_n = 0; ncl = 0; viol_w = 0; viol_busy = 0; viol_oe = 0;
    ce_cnt = 0; done_cnt = 0; done_t = 0; rb_rise_t = 0; post_rise_t = 0;
    we_ok = 0; re_ok = 0; rd_idx = 0; pat_seed = int'($urandom % 256);
    exp_lo = atl1(int'(cfg_we_lo)); exp_hi = atl1(int'(cfg_we_hi)); exp_rlo = atl1(int'(cfg_re_lo));
    plan_wait = pwait; plan_len = plen;
    @(negedge clk);
    req_cmd = c; req_addr = a; req_naddr = 3'(na); req_row_only = ro;
    req_has_post = hp; req_post_cmd = pc; req_nread = 8'(nr); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (bad) begin
      chk(err == 1'b1, "R8 err pulse on reject", int'(err), 1);
      repeat (4) @(negedge clk);
      chk(ev_n == 0, "R8 no latches on reject", ev_n, 0);
      chk(ce_cnt == 0, "R8 chip stays deselected", ce_cnt, 0);
      chk(done_cnt == 0, "R8 no done on reject", done_cnt, 0);
      return;
    end
    chk(busy == 1'b1 && req_ready == 1'b0, "R9 busy after accept", int'(busy), 1);
    while (done_cnt == 0 && g < 20000) begin @(negedge clk); g++; end
    repeat (2) @(negedge clk);
    chk(done_cnt == 1, "R9 single done pulse", done_cnt, 1);
    chk(ev_n == exp_n, "R1 latch count", ev_n, exp_n);
    for (int i = 0; i < exp_n && i < ev_n; i++) begin
      if (dummy && i == 0)
        chk(ev_kind[i] == 2'b01 && ev_byte[i] == 8'h00, "R7 dummy command first", int'(ev_byte[i]), 0);
      else if (exp_kind[i] == 2'b10)
        chk(ev_kind[i] == 2'b10 && ev_byte[i] == exp_byte[i], "R3 address byte", int'(ev_byte[i]), int'(exp_byte[i]));
      else
        chk(ev_kind[i] == 2'b01 && ev_byte[i] == exp_byte[i], "R1 command byte", int'(ev_byte[i]), int'(exp_byte[i]));
    end
    chk(rd_n == nr, "R6 read byte count", rd_n, nr);
    for (int i = 0; i < nr && i < rd_n; i++)
      chk(rd_got[i] == 8'((i * 29 + pat_seed) % 256), "R6 read data", int'(rd_got[i]), (i * 29 + pat_seed) % 256);
    chk(viol_w == 0, "R4 strobe widths", viol_w, 0);
    chk(viol_oe == 0 && nand_dq_oe == 0, "R6 bus released on read/idle", viol_oe, 0);
    chk(viol_busy == 0, "R5 no read strobe while busy", viol_busy, 0);
    chk(ce_cnt > 0 && nand_ce_n == 1'b1, "R2 chip enable window", ce_cnt, 1);
    if (hp && pwait < 0)
      chk(done_t - post_rise_t >= int'(cfg_busy_to), "R5 timeout wait", done_t - post_rise_t, int'(cfg_busy_to));
    if (hp && pwait >= 0)
      chk(rb_rise_t > 0 && done_t > rb_rise_t, "R5 done after ready", done_t, rb_rise_t + 1);
    id_state = (c == 8'h90);
  endtask

  initial begin
    void'($urandom(32'd1234));
    id_state = 0;
    repeat (3) @(negedge clk);
    chk(nand_ce_n && nand_we_n && nand_re_n, "R2 reset deselected", int'(nand_ce_n), 1);
    chk(!nand_dq_oe, "R6 reset bus released", int'(nand_dq_oe), 0);
    chk(!busy && !done && !err, "R9 reset idle", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready after reset", int'(req_ready), 1);
    // identification read, then status twice
    run_req(8'h90, 31'h0, 1, 0, 0, 8'h00, 5, 0, 0);
    run_req(8'h70, 31'h0, 0, 0, 0, 8'h00, 1, 0, 0);
    run_req(8'h70, 31'h0, 0, 0, 0, 8'h00, 1, 0, 0);
    // full page read with busy wait
    cfg_we_lo = 3; cfg_we_hi = 2; cfg_re_lo = 2; cfg_rd_dly = 3;
    run_req(8'h00, 31'h5ABC_DEF1, 5, 0, 1, 8'h30, 4, 3, 25);
    // row-only erase, zero counts act as one
    cfg_we_lo = 0; cfg_we_hi = 0; cfg_re_lo = 0; cfg_rd_dly = 0;
    run_req(8'h60, 31'h7FFF_FFFF, 3, 1, 1, 8'hD0, 0, 1, 60);
    // ready/busy never drops: timeout path
    cfg_busy_to = 12;
    run_req(8'h80, 31'h0004_0800, 5, 0, 1, 8'h10, 2, -1, 0);
    cfg_busy_to = 40;
    // rejections
    run_req(8'h00, 31'h1, 6, 0, 0, 8'h00, 1, 0, 0);
    run_req(8'h00, 31'h1, 7, 0, 0, 8'h00, 0, 0, 0);
    run_req(8'h60, 31'h1, 4, 1, 1, 8'hD0, 0, 0, 0);
    // random mix
    for (int n = 0; n < 48; n++) begin
      logic [7:0] cl [0:5];
      int na, nr, pw;
      bit ro, hp;
      cl[0] = 8'h00; cl[1] = 8'h90; cl[2] = 8'h70; cl[3] = 8'h60; cl[4] = 8'hEF;
      cl[5] = 8'($urandom);
      cfg_we_lo = 6'($urandom % 4); cfg_we_hi = 6'($urandom % 4);
      cfg_re_lo = 6'($urandom % 4); cfg_rd_dly = 6'($urandom % 4);
      ro = 1'($urandom % 2);
      na = int'($urandom % 8);
      if (!ro && na > 5 && ($urandom % 3) != 0) na = 5;
      if (ro && na > 3 && ($urandom % 3) != 0) na = 3;
      hp = 1'($urandom % 2);
      nr = int'($urandom % 6);
      pw = int'($urandom % 6);
      run_req(cl[$urandom % 6], 31'($urandom), na, ro, hp, 8'($urandom), nr, pw, int'($urandom % 30));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule